// File: doc/BRIEF.md
# Fractional Baud Clock Prescaler

This block sits ahead of a baud divisor stage and slows the reference clock by a programmable factor that has a fractional part. The factor runs from 1.000 to 31.875 in steps of one eighth, 248 distinct settings in all. The block emits a one-cycle enable pulse for each prescaled period. A fractional factor is produced by dithering. A small accumulator adds the eighths field once per period, and each carry out of it stretches the next period by one reference cycle. The average period over eight pulses is therefore exact.

A bypass is selected by a mode input. In this mode an external bit clock pin drives the enable directly at 1x, so the bit rate can run up to the synchronizer limit rather than the prescaled rate. The pin is resynchronized to the reference clock. One enable pulse is made for each rising edge of the pin. While the bypass is active, the divider is held in its restart state.

Top module: `frac_prescaler`

## Requirements
- R1: After reset the factor is 1.000, and `tick` is high in every cycle while `ext_mode` is low.
- R2: The configuration byte holds the integer part M in bits [7:3] and the eighths N in bits [2:0]. For M of 1 or more, count the first cycle after a write edge as cycle 0. The j-th tick (j = 0, 1, ...) then falls in cycle (j+1)*M + floor(j*N/8) - 1.
- R3: Every internal period lasts M or M+1 reference cycles. A 3-bit accumulator gains N at each period end, and it is a carry out of that accumulator that selects M+1 for the following period.
- R4: An integer part of 0 acts as a factor of exactly 1: `tick` is high every cycle and N has no effect.
- R5: A write restarts the divider. The next period starts in the cycle after the write edge and the accumulator starts from 0. In the cycle that carries the write, `tick` still reflects the period that was running.
- R6: With `ext_mode` high, `tick` follows `ext_clk_pin` through a two-flop synchronizer. The pin level sampled at edge k, when it is high and the level at edge k-1 was low, gives a single-cycle `tick` in the cycle after edge k+1. There is exactly one pulse per rising edge of the pin.
- R7: While `ext_mode` is high, the divider is held cleared. In the cycle where `ext_mode` goes low, counting resumes as cycle 0 of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the factor register |
| cfg_wdata | input | 8 | New factor: integer in [7:3], eighths in [2:0] |
| ext_mode | input | 1 | High selects the external 1x bit clock |
| ext_clk_pin | input | 1 | External bit clock, asynchronous |
| tick | output | 1 | One-cycle enable at the prescaled or external rate |

## Verification
A write can land in the same cycle as a period-ending tick. The bench provokes this by waiting for a sampled tick and raising the write strobe in that same cycle. It then expects the tick to stay visible there, and expects the new factor's tick pattern to start counting from the cycle after the edge. Every register value is also swept, and the observed tick cycles are compared against the closed-form schedule of R2. The bench also leaves bypass mode with a fractional factor loaded, so that leaving the bypass and restarting the dither happen together.

// File: rtl/frac_prescaler.sv
module frac_prescaler #(
  parameter int INT_W  = 5,
  parameter int FRAC_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [INT_W+FRAC_W-1:0]   cfg_wdata,
  input  logic                      ext_mode,
  input  logic                      ext_clk_pin,
  output logic                      tick
);
  localparam int CFG_W = INT_W + FRAC_W;
  localparam int LEN_W = INT_W + 1;
  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(1) << FRAC_W;

  logic [CFG_W-1:0]  cfg;
  logic [LEN_W-1:0]  cnt, len;
  logic [FRAC_W-1:0] acc;
  logic [2:0]        sync;

  wire [INT_W-1:0]  m_raw   = cfg[CFG_W-1:FRAC_W];
  wire              m_zero  = (m_raw == '0);
  wire [LEN_W-1:0]  m_eff   = m_zero ? LEN_W'(1) : {1'b0, m_raw};
  wire [FRAC_W-1:0] n_eff   = m_zero ? '0 : cfg[FRAC_W-1:0];

  wire [INT_W-1:0]  w_raw   = cfg_wdata[CFG_W-1:FRAC_W];
  wire [LEN_W-1:0]  w_m_eff = (w_raw == '0) ? LEN_W'(1) : {1'b0, w_raw};

  wire [FRAC_W:0]   sum        = {1'b0, acc} + {1'b0, n_eff};
  wire              period_end = (cnt == len - LEN_W'(1));
  wire              ext_pulse  = sync[1] & ~sync[2];

  assign tick = ext_mode ? ext_pulse : period_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg  <= CFG_RESET;
      cnt  <= '0;
      len  <= LEN_W'(1);
      acc  <= '0;
      sync <= '0;
    end else begin
      sync <= {sync[1:0], ext_clk_pin};
      if (cfg_we) begin
        cfg <= cfg_wdata;
        cnt <= '0;
        acc <= '0;
        len <= w_m_eff;
      end else if (ext_mode) begin
        cnt <= '0;
        acc <= '0;
        len <= m_eff;
      end else if (period_end) begin
        cnt <= '0;
        acc <= sum[FRAC_W-1:0];
        len <= m_eff + LEN_W'(sum[FRAC_W]);
      end else begin
        cnt <= cnt + LEN_W'(1);
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len); // R3
  AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (len == m_eff) || (len == m_eff + LEN_W'(1))); // R3
  AST_ZERO_INT_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_zero && !ext_mode) |-> tick); // R4
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cnt == '0) && (acc == '0)); // R5
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !cfg_we) |=> (cnt == '0) && (acc == '0)); // R7
  AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && tick) |=> (!tick || !ext_mode)); // R6
endmodule

// File: tb/sim_frac_prescaler.sv
module sim_frac_prescaler;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_we = 0;
  logic [7:0] cfg_wdata = 0;
  logic       ext_mode = 0;
  logic       ext_clk_pin = 0;
  logic       tick;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  frac_prescaler u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
                     .ext_mode(ext_mode), .ext_clk_pin(ext_clk_pin), .tick(tick));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_check(input int m, input int n, input int ticks, input string tag);
    int j, c, next_t, bad_c;
    logic exp, bad_got, bad_exp;
    bit bad;
    j = 0; c = 0; bad = 0; next_t = m - 1;
    bad_c = 0; bad_got = 0; bad_exp = 0;
    while (j < ticks) begin
      exp = (c == next_t);
      if (tick !== exp && !bad) begin
        bad = 1; bad_c = c; bad_got = tick; bad_exp = exp;
      end
      if (exp) begin
        j++;
        next_t = (j + 1) * m + (j * n) / 8 - 1;
      end
      c++;
      step();
    end
    tests++;
    if (bad) begin
      fails++;
      $display("FAIL %s M=%0d N=%0d cycle %0d: tick got %0b expected %0b",
               tag, m, n, bad_c, bad_got, bad_exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v;
    step();
    cfg_we = 0;
  endtask

  task automatic ext_pattern(input int hi, input int lo, input int cycles);
    logic [2:0] h;
    int rises, pulses;
    bit bad;
    h = '0; rises = 0; pulses = 0; bad = 0;
    ext_clk_pin = 0;
    repeat (4) step();
    for (int c = 0; c < cycles + 4; c++) begin
      logic exp, nxt;
      exp = h[1] & ~h[2];
      if (tick !== exp) bad = 1;
      if (tick === 1'b1) pulses++;
      nxt = (c < cycles) ? (((c % (hi + lo)) < hi) ? 1'b1 : 1'b0) : 1'b0;
      if (nxt && !h[0]) rises++;
      ext_clk_pin = nxt;
      h = {h[1:0], nxt};
      step();
    end
    tests++;
    if (bad || pulses != rises) begin
      fails++;
      $display("FAIL R6 hi=%0d lo=%0d: pulses %0d expected %0d (timing mismatch=%0b expected 0)",
               hi, lo, pulses, rises, bad);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    rst_n = 1;
    step();
    // R1: reset factor 1.000, tick every cycle
    for (int k = 0; k < 6; k++) begin
      tests++;
      if (tick !== 1'b1) begin
        fails++;
        $display("FAIL R1 cycle %0d: tick got %0b expected 1", k, tick);
      end
      step();
    end

    // R2 R3 R4: sweep every register value
    for (int v = 0; v < 256; v++) begin
      int m, n;
      m = v >> 3; n = v & 7;
      if (m == 0) begin m = 1; n = 0; end
      write_cfg(8'(v));
      run_check(m, n, 9, (v < 8) ? "R4" : "R2/R3");
    end

    // R5: write in the same cycle as a period-ending tick
    write_cfg(8'h18);
    while (tick !== 1'b1) step();
    cfg_we = 1; cfg_wdata = 8'h10;
    #1;
    tests++;
    if (tick !== 1'b1) begin
      fails++;
      $display("FAIL R5 write cycle: tick got %0b expected 1", tick);
    end
    step();
    cfg_we = 0;
    run_check(2, 0, 6, "R5");

    // R5: write mid-period with fractional value restarts accumulator
    write_cfg(8'h2B);
    step(); step();
    write_cfg(8'h2B);
    run_check(5, 3, 9, "R5");

    // R6: external 1x clock patterns
    write_cfg(8'h3D);
    ext_mode = 1;
    ext_pattern(1, 1, 40);
    ext_pattern(2, 1, 40);
    ext_pattern(1, 3, 40);
    ext_pattern(3, 2, 40);

    // R7: leaving bypass restarts the divider with a fractional factor
    ext_clk_pin = 0;
    repeat (5) step();
    ext_mode = 0;
    #1;
    run_check(7, 5, 9, "R7");

    // R7: write during bypass takes effect on exit
    ext_mode = 1;
    write_cfg(8'h1A);
    repeat (3) step();
    ext_mode = 0;
    #1;
    run_check(3, 2, 9, "R7");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule